// File: doc/BRIEF.md
# Grouped Single-Error-Correcting Byte Store

This block is a byte-addressed storage path that keeps its contents as aligned 4-byte groups. Each group is held in one 38-bit internal RAM word: 32 data bits plus 6 Hamming check bits. Every write encodes the group. Every read decodes it and repairs any one flipped bit before the requested byte is returned. A corrected-error flag marks reads whose data needed repair.

A host issues one request at a time through a valid/ready pair. Each request is a byte read, a byte write or a full-group write. A full-group write replaces all four bytes and is encoded straight from the request, so it needs no read. A byte write cannot update its check bits in isolation. The block therefore reads the whole group, corrects it, merges the new byte and re-encodes all four bytes. A side port flips one stored bit so that the correction logic can be exercised.

Top module: `secc_store`

## Requirements
- R1: After reset, ready_o is 1 and rvalid_o and corr_o are 0.
- R2: A byte read accepted on a clock edge (req_valid_i and ready_o high, req_we_i low) returns the byte on rdata_o with rvalid_o high for exactly one cycle, starting after the next edge. Byte lane k = req_addr_i[1:0] maps to group bits 8k+7:8k, and the group index is req_addr_i[ADDR_W-1:2].
- R3: A full-group write (req_we_i and req_full_i high) stores all 32 bits of req_wdata_i in one cycle, ignores req_addr_i[1:0], and leaves ready_o high on the following cycle.
- R4: A byte write (req_we_i high, req_full_i low) replaces only lane req_addr_i[1:0] with req_wdata_i[7:0], and the other three bytes of the group keep their values.
- R5: A byte write or byte read occupies two cycles, and ready_o is low during the cycle after it is accepted.
- R6: When any one of the 38 bits of a stored word is flipped, a read of any byte of that group returns the original byte with corr_o high.
- R7: A read of a group with no flipped bit returns corr_o low.
- R8: A byte write to a group that holds one flipped bit corrects the old bytes before merging, so later reads of that group return the original bytes for the other lanes with corr_o low.
- R9: corr_o is never high unless rvalid_o is high.
- R10: A pulse on dbg_flip_i with ready_o high and req_valid_i low inverts stored bit dbg_bit_i of group dbg_grp_i. Bit indices 38 and above have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_full_i | input | 1 | With req_we_i: write whole group |
| req_addr_i | input | ADDR_W (8) | Byte address |
| req_wdata_i | input | 32 | Write data (bits 7:0 for byte writes) |
| ready_o | output | 1 | Request accepted when high |
| rdata_o | output | 8 | Read byte |
| rvalid_o | output | 1 | Read data valid pulse |
| corr_o | output | 1 | Returned read data was corrected |
| dbg_flip_i | input | 1 | Flip one stored bit |
| dbg_grp_i | input | GRP_W (6) | Group index to corrupt |
| dbg_bit_i | input | 6 | Codeword bit index to flip |

## Verification
The assertions assume that the host presents a request only while ready_o is high and holds it for exactly one accepting edge. They also assume that flips are injected only while no request is pending. The stimulus drives on falling edges, lowers req_valid_i straight after the accepting edge, and issues flips only between requests. Reads are made only of groups written since reset, so the checks never depend on uninitialised RAM contents.

// File: rtl/secc_pkg.sv
package secc_pkg;
  localparam int DATA_W = 32;
  localparam int CHK_W  = 6;
  localparam int CW_W   = DATA_W + CHK_W;

  function automatic logic is_pow2(int unsigned p);
    return (p & (p - 1)) == 0;
  endfunction

  // Hamming positions 1..CW_W; check bits at powers of two
  function automatic logic [CW_W-1:0] hc_encode(logic [DATA_W-1:0] d);
    logic [CW_W-1:0] cw;
    int unsigned k;
    cw = '0;
    k  = 0;
    for (int unsigned p = 1; p <= CW_W; p++) begin
      if (!is_pow2(p)) begin
        cw[p-1] = d[k];
        k++;
      end
    end
    for (int unsigned j = 0; j < CHK_W; j++) begin
      logic par;
      par = 1'b0;
      for (int unsigned p = 1; p <= CW_W; p++)
        if (((p >> j) & 1) == 1 && !is_pow2(p)) par ^= cw[p-1];
      cw[(1 << j) - 1] = par;
    end
    return cw;
  endfunction

  function automatic logic [DATA_W-1:0] hc_extract(logic [CW_W-1:0] cw);
    logic [DATA_W-1:0] d;
    int unsigned k;
    d = '0;
    k = 0;
    for (int unsigned p = 1; p <= CW_W; p++) begin
      if (!is_pow2(p)) begin
        d[k] = cw[p-1];
        k++;
      end
    end
    return d;
  endfunction
endpackage

// File: rtl/secc_enc.sv
module secc_enc
  import secc_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CW_W-1:0]   cw_o
);
  assign cw_o = hc_encode(data_i);
endmodule

// File: rtl/secc_dec.sv
module secc_dec
  import secc_pkg::*;
(
  input  logic [CW_W-1:0]   cw_i,
  output logic [DATA_W-1:0] data_o,
  output logic              err_o
);
  logic [CHK_W-1:0] syn;
  logic [CW_W-1:0]  fixed;

  always_comb begin
    syn = '0;
    for (int unsigned p = 1; p <= CW_W; p++)
      if (cw_i[p-1]) syn ^= CHK_W'(p);
  end

  always_comb begin
    fixed = cw_i;
    if (syn != '0 && int'(syn) <= CW_W)
      fixed = cw_i ^ (CW_W'(1) << (syn - CHK_W'(1)));
  end

  assign data_o = hc_extract(fixed);
  assign err_o  = (syn != '0);
endmodule

// File: rtl/secc_merge.sv
module secc_merge #(
  parameter int LANES = 4
) (
  input  logic [LANES*8-1:0]       old_i,
  input  logic [7:0]               byte_i,
  input  logic [$clog2(LANES)-1:0] lane_i,
  output logic [LANES*8-1:0]       new_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign new_o[8*k +: 8] = (int'(lane_i) == k) ? byte_i : old_i[8*k +: 8];
  end
endmodule

// File: rtl/secc_store.sv
module secc_store
  import secc_pkg::*;
#(
  parameter int GROUPS = 64,
  parameter int GRP_W  = $clog2(GROUPS),
  parameter int ADDR_W = GRP_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic              req_full_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              ready_o,
  output logic [7:0]        rdata_o,
  output logic              rvalid_o,
  output logic              corr_o,
  input  logic              dbg_flip_i,
  input  logic [GRP_W-1:0]  dbg_grp_i,
  input  logic [5:0]        dbg_bit_i
);
  localparam int LANE_W = 2;

  typedef enum logic {ST_IDLE, ST_LOOK} state_e;
  state_e state_q;

  logic [CW_W-1:0]   mem [GROUPS];
  logic [CW_W-1:0]   rd_word_q;
  logic [GRP_W-1:0]  grp_q;
  logic [LANE_W-1:0] lane_q;
  logic              we_q;
  logic [7:0]        wbyte_q;

  logic              accept;
  logic [GRP_W-1:0]  grp_in;
  logic [DATA_W-1:0] dec_data, merged, enc_in;
  logic              dec_err;
  logic [CW_W-1:0]   enc_cw;
  logic              mem_we;
  logic [GRP_W-1:0]  mem_waddr;
  logic [CW_W-1:0]   mem_wdata;

  assign ready_o = (state_q == ST_IDLE);
  assign accept  = req_valid_i && ready_o;
  assign grp_in  = req_addr_i[ADDR_W-1:LANE_W];

  secc_dec i_dec (.cw_i(rd_word_q), .data_o(dec_data), .err_o(dec_err));

  secc_merge #(.LANES(4)) i_merge (
    .old_i(dec_data), .byte_i(wbyte_q), .lane_i(lane_q), .new_o(merged)
  );

  assign enc_in = (state_q == ST_LOOK) ? merged : req_wdata_i;
  secc_enc i_enc (.data_i(enc_in), .cw_o(enc_cw));

  always_comb begin
    mem_we    = 1'b0;
    mem_waddr = grp_in;
    mem_wdata = enc_cw;
    if (state_q == ST_LOOK) begin
      mem_we    = we_q;
      mem_waddr = grp_q;
    end else if (accept) begin
      mem_we    = req_we_i && req_full_i;
    end else if (dbg_flip_i && int'(dbg_bit_i) < CW_W) begin
      mem_we    = 1'b1;
      mem_waddr = dbg_grp_i;
      mem_wdata = mem[dbg_grp_i] ^ (CW_W'(1) << dbg_bit_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (mem_we) mem[mem_waddr] <= mem_wdata;
  end

  always_ff @(posedge clk_i) begin
    if (accept) begin
      rd_word_q <= mem[grp_in];
      grp_q     <= grp_in;
      lane_q    <= req_addr_i[LANE_W-1:0];
      wbyte_q   <= req_wdata_i[7:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      we_q     <= 1'b0;
      rvalid_o <= 1'b0;
      corr_o   <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= 1'b0;
      corr_o   <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept && !(req_we_i && req_full_i)) begin
            state_q <= ST_LOOK;
            we_q    <= req_we_i;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          if (!we_q) begin
            rvalid_o <= 1'b1;
            corr_o   <= dec_err;
            rdata_o  <= dec_data[8*lane_q +: 8];
          end
        end
      endcase
    end
  end

  AST_READ_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !req_we_i) |=> (state_q == ST_LOOK) ##1 rvalid_o) else $error("read resp"); // R2
  AST_RVALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o) else $error("rvalid pulse"); // R2
  AST_FULL_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && req_we_i && req_full_i) |=> ready_o) else $error("full write busy"); // R3
  AST_PARTIAL_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !(req_we_i && req_full_i)) |=> !ready_o) else $error("partial not busy"); // R5
  AST_CORR_WITH_RVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_o |-> rvalid_o) else $error("corr without rvalid"); // R9
endmodule

// File: tb/test_secc_store.sv
module test_secc_store;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0, req_full = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        ready, rvalid, corr;
  logic [7:0]  rdata;
  logic        dbg_flip = 1'b0;
  logic [5:0]  dbg_grp = '0;
  logic [5:0]  dbg_bit = '0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  secc_store i_secc_store (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_we_i(req_we),
    .req_full_i(req_full), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .ready_o(ready), .rdata_o(rdata), .rvalid_o(rvalid), .corr_o(corr),
    .dbg_flip_i(dbg_flip), .dbg_grp_i(dbg_grp), .dbg_bit_i(dbg_bit)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // kind: 0 read, 1 byte write, 2 full write
  logic       busy_s, rv_s, cr_s;
  logic [7:0] rd_s;
  task automatic op(int kind, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = (kind != 0); req_full = (kind == 2);
    req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    busy_s = !ready;
    rv_s = 1'b0; cr_s = 1'b0; rd_s = '0;
    if (kind != 2) begin
      @(posedge clk);
      @(negedge clk);
      rv_s = rvalid; cr_s = corr; rd_s = rdata;
    end
  endtask

  task automatic flip(logic [5:0] g, logic [5:0] b);
    @(negedge clk);
    dbg_flip = 1'b1; dbg_grp = g; dbg_bit = b;
    @(negedge clk);
    dbg_flip = 1'b0;
  endtask

  // {kind[3:0], addr[7:0], data[31:0]}; reads expect data[7:0]
  localparam int NV = 12;
  localparam logic [43:0] VEC [NV] = '{
    {4'd2, 8'h00, 32'h44332211},
    {4'd0, 8'h00, 32'h00000011},
    {4'd0, 8'h01, 32'h00000022},
    {4'd0, 8'h02, 32'h00000033},
    {4'd0, 8'h03, 32'h00000044},
    {4'd2, 8'h06, 32'hA5A5A5A5},
    {4'd1, 8'h05, 32'h0000003C},
    {4'd0, 8'h04, 32'h000000A5},
    {4'd0, 8'h05, 32'h0000003C},
    {4'd0, 8'h06, 32'h000000A5},
    {4'd0, 8'h07, 32'h000000A5},
    {4'd1, 8'h03, 32'h000000EE}
  };

  initial begin
    #3;
    chk("R1 ready", 32'(ready), 1);
    chk("R1 rvalid", 32'(rvalid), 0);
    chk("R1 corr", 32'(corr), 0);
    #10 rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      int k;
      k = int'(VEC[i][43:40]);
      op(k, VEC[i][39:32], VEC[i][31:0]);
      if (k == 0) begin
        chk("R2 rdata", 32'(rd_s), 32'(VEC[i][7:0]));
        chk("R2 rvalid", 32'(rv_s), 1);
        chk("R7 clean corr", 32'(cr_s), 0);
        chk("R5 read busy", 32'(busy_s), 1);
      end else if (k == 2) begin
        chk("R3 stays ready", 32'(busy_s), 0);
      end else begin
        chk("R5 byte write busy", 32'(busy_s), 1);
        chk("R9 no rvalid on write", 32'(rv_s), 0);
      end
    end
    // R4: lane 3 replaced, others kept
    op(0, 8'h00, 0); chk("R4 lane0 kept", 32'(rd_s), 32'h11);
    op(0, 8'h03, 0); chk("R4 lane3 new", 32'(rd_s), 32'hEE);
    // R2: rvalid is a one-cycle pulse
    @(negedge clk); chk("R2 pulse ends", 32'(rvalid), 0);

    // R3: low address bits ignored on full write
    op(2, 8'h0B, 32'hDEADBEEF);
    op(0, 8'h08, 0); chk("R3 lane0", 32'(rd_s), 32'hEF);
    op(0, 8'h0B, 0); chk("R3 lane3", 32'(rd_s), 32'hDE);

    // R6: every codeword bit position corrected
    for (int b = 0; b < 38; b++) begin
      logic [31:0] w;
      w = 32'h9C5A_0F31 ^ 32'(b * 32'h01010101);
      op(2, 8'h10, w);
      flip(6'd4, 6'(b));
      op(0, 8'(8'h10 + (b % 4)), 0);
      chk("R6 corrected data", 32'(rd_s), 32'(w[8*(b%4) +: 8]));
      chk("R6 corr flag", 32'(cr_s), 1);
      chk("R9 corr with rvalid", 32'(rv_s), 1);
    end

    // R8: byte write scrubs a flipped group
    op(2, 8'h14, 32'h87654321);
    flip(6'd5, 6'd20);
    op(1, 8'h15, 32'h77);
    op(0, 8'h14, 0);
    chk("R8 lane0 value", 32'(rd_s), 32'h21);
    chk("R8 corr clear", 32'(cr_s), 0);
    op(0, 8'h17, 0); chk("R8 lane3 value", 32'(rd_s), 32'h87);
    op(0, 8'h15, 0); chk("R8 merged lane", 32'(rd_s), 32'h77);

    // R10: out-of-range flip index has no effect
    op(2, 8'h18, 32'h0BADF00D);
    flip(6'd6, 6'd38);
    flip(6'd6, 6'd63);
    op(0, 8'h18, 0);
    chk("R10 ignored flip data", 32'(rd_s), 32'h0D);
    chk("R10 ignored flip corr", 32'(cr_s), 0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule